// File: doc/BRIEF.md
# I2C serial clock timing generator

This block derives an I2C serial clock from a fast functional clock. A programmable prescaler divides the functional clock by one more than its setting. The divided clock then drives two phase counters. Each SCL period is a low phase followed by a high phase. Each phase lasts the programmed count plus a fixed overhead: seven prescaled ticks for the low phase and five for the high phase. The full period in functional clocks is therefore (psc+1) × (low + 7 + high + 5).

Each count register is sixteen bits wide and holds two counts. The lower byte is used for standard and fast operation. The upper byte is used only while the high-speed select input is set. Settings are captured at the start of each period, so a change applied while the clock runs never produces a truncated or stretched phase. While the block is disabled, SCL is released high and the counters are held cleared. Once per period, in the middle of the high phase, a one-cycle strobe tells the bit engine when to sample SDA.

With a 48 MHz functional clock, these settings give the three standard rates: psc=1 with counts 111/117 gives 100 kHz, psc=1 with 23/25 gives 400 kHz, and psc=1 with 5/7 gives 1 MHz.

Top module: `scl_timing_gen`

## Requirements
- R1: While enabled with stable settings, the SCL period is (psc+1)·(L+7+H+5) functional clocks, where L and H are the selected low and high counts. For example, psc=1, L=111, H=117 gives 480 cycles, and psc=1 with 23/25 or 5/7 gives 120 or 48 cycles.
- R2: Each period starts with SCL low for (psc+1)·(L+7) cycles, followed by SCL high for (psc+1)·(H+5) cycles.
- R3: The cycle after enable is sampled low, SCL is 1 and sample_tick is 0, and both stay that way while enable remains low. Reset gives the same state.
- R4: When hs_mode is 1, L and H are taken from bits [15:8] of low_cnt and high_cnt. When hs_mode is 0, they are taken from bits [7:0].
- R5: A settings change (psc, counts or hs_mode) made during a period has no effect on that period. It takes effect from the next period.
- R6: sample_tick pulses for exactly one cycle per period, while SCL is high. The pulse comes (psc+1)·floor((H+5)/2) cycles after SCL rises.
- R7: With psc=0 and both counts 0, the period is 12 cycles, made up of 7 cycles low and 5 cycles high.
- R8: After enable rises, SCL goes low on the next cycle. The first low phase is full length, using the settings present when enable was first sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator; low releases SCL and clears the counters |
| hs_mode | input | 1 | Selects the upper-byte (high-speed) count pair |
| psc | input | 8 | Prescaler setting; divide by psc+1 |
| low_cnt | input | 16 | [15:8] high-speed low count, [7:0] normal low count |
| high_cnt | input | 16 | [15:8] high-speed high count, [7:0] normal high count |
| scl_out | output | 1 | Serial clock; 1 means released high |
| sample_tick | output | 1 | One-cycle strobe at mid high phase |

## Verification
The assertions assume that enable and the settings change only between clock edges and are otherwise arbitrary. They also assume that the fixed overheads keep every phase at least two prescaled ticks long, so a falling edge of SCL is always followed by another low cycle and a tick is never followed by another tick. The stimulus changes inputs only on falling clock edges. It covers the three rate settings, the smallest settings, high-speed selection, a mid-period settings change, and a disable that occurs mid-period. A behavioural reference model, based on a per-period cycle position, is compared with SCL and the tick on every clock.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;
   typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} scl_phase_e;

   function automatic int unsigned ph_width(input int unsigned cnt_w);
      return cnt_w + 1;
   endfunction
endpackage

// File: rtl/scl_cfg_latch.sv
module scl_cfg_latch #(
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned PSC_W    = 8,
   parameter int unsigned LOW_OVH  = 7,
   parameter int unsigned HIGH_OVH = 5,
   parameter bit          HS_EN    = 1'b1,
   localparam int unsigned REG_W   = 2 * CNT_W,
   localparam int unsigned PH_W    = CNT_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             hs_sel,
   input  logic [PSC_W-1:0] psc_in,
   input  logic [REG_W-1:0] low_in,
   input  logic [REG_W-1:0] high_in,
   output logic [PSC_W-1:0] psc_q,
   output logic [PH_W-1:0]  low_len_q,
   output logic [PH_W-1:0]  high_len_q
);
   localparam logic [PH_W-1:0] LOW_ADD  = PH_W'(LOW_OVH);
   localparam logic [PH_W-1:0] HIGH_ADD = PH_W'(HIGH_OVH);

   logic [CNT_W-1:0] low_pick;
   logic [CNT_W-1:0] high_pick;

   generate
      if (HS_EN) begin : g_hs_mux
         assign low_pick  = hs_sel ? low_in[REG_W-1:CNT_W]  : low_in[CNT_W-1:0];
         assign high_pick = hs_sel ? high_in[REG_W-1:CNT_W] : high_in[CNT_W-1:0];
      end else begin : g_no_hs
         logic unused_upper;
         assign unused_upper = ^{hs_sel, low_in[REG_W-1:CNT_W], high_in[REG_W-1:CNT_W]};
         assign low_pick  = low_in[CNT_W-1:0];
         assign high_pick = high_in[CNT_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psc_q      <= '0;
         low_len_q  <= LOW_ADD;
         high_len_q <= HIGH_ADD;
      end else if (load) begin
         psc_q      <= psc_in;
         low_len_q  <= PH_W'(low_pick) + LOW_ADD;
         high_len_q <= PH_W'(high_pick) + HIGH_ADD;
      end
   end
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
   parameter int unsigned PSC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic [PSC_W-1:0] div_m1,
   output logic             step,
   output logic             at_zero
);
   logic [PSC_W-1:0] cnt_q;

   assign step    = !hold && (cnt_q == div_m1);
   assign at_zero = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (hold)     cnt_q <= '0;
      else if (step)     cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr
   import scl_timing_pkg::*;
#(
   parameter int unsigned PH_W = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hold,
   input  logic            step,
   input  logic [PH_W-1:0] low_len,
   input  logic [PH_W-1:0] high_len,
   output scl_phase_e      phase,
   output logic            period_end,
   output logic            at_mid_high
);
   logic [PH_W-1:0] cnt_q;
   logic [PH_W-1:0] cur_last;
   logic            phase_done;

   assign cur_last    = ((phase == PH_HIGH) ? high_len : low_len) - 1'b1;
   assign phase_done  = step && (cnt_q == cur_last);
   assign period_end  = phase_done && (phase == PH_HIGH);
   assign at_mid_high = (phase == PH_HIGH) && (cnt_q == (high_len >> 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         phase <= PH_LOW;
      end else if (hold) begin
         cnt_q <= '0;
         phase <= PH_LOW;
      end else if (phase_done) begin
         cnt_q <= '0;
         phase <= (phase == PH_HIGH) ? PH_LOW : PH_HIGH;
      end else if (step) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
   import scl_timing_pkg::*;
#(
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned PSC_W    = 8,
   parameter int unsigned LOW_OVH  = 7,
   parameter int unsigned HIGH_OVH = 5,
   parameter bit          HS_EN    = 1'b1,
   localparam int unsigned REG_W   = 2 * CNT_W,
   localparam int unsigned PH_W    = CNT_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             hs_mode,
   input  logic [PSC_W-1:0] psc,
   input  logic [REG_W-1:0] low_cnt,
   input  logic [REG_W-1:0] high_cnt,
   output logic             scl_out,
   output logic             sample_tick
);
   generate
      if (LOW_OVH < 2 || HIGH_OVH < 2) begin : g_bad_ovh
         $error("scl_timing_gen: each phase overhead must be at least 2");
      end
      if (LOW_OVH >= (1 << CNT_W) || HIGH_OVH >= (1 << CNT_W)) begin : g_bad_fit
         $error("scl_timing_gen: overhead does not fit the phase counter");
      end
      if (PH_W != ph_width(CNT_W)) begin : g_bad_w
         $error("scl_timing_gen: phase width mismatch");
      end
   endgenerate

   logic             run_q;
   logic             hold;
   logic             step;
   logic             pre_zero;
   logic             period_end;
   logic             at_mid;
   logic             load;
   scl_phase_e       phase;
   logic [PSC_W-1:0] psc_q;
   logic [PH_W-1:0]  low_len;
   logic [PH_W-1:0]  high_len;

   assign hold = !(enable && run_q);
   assign load = hold || period_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= enable;
   end

   scl_cfg_latch #(
      .CNT_W(CNT_W), .PSC_W(PSC_W), .LOW_OVH(LOW_OVH),
      .HIGH_OVH(HIGH_OVH), .HS_EN(HS_EN)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .load(load), .hs_sel(hs_mode),
      .psc_in(psc), .low_in(low_cnt), .high_in(high_cnt),
      .psc_q(psc_q), .low_len_q(low_len), .high_len_q(high_len)
   );

   scl_prescaler #(.PSC_W(PSC_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .hold(hold), .div_m1(psc_q),
      .step(step), .at_zero(pre_zero)
   );

   scl_phase_ctr #(.PH_W(PH_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .hold(hold), .step(step),
      .low_len(low_len), .high_len(high_len),
      .phase(phase), .period_end(period_end), .at_mid_high(at_mid)
   );

   assign scl_out     = !run_q || (phase == PH_HIGH);
   assign sample_tick = run_q && at_mid && pre_zero;
endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic scl_out,
   input logic sample_tick
);
   // R3: disabled means released line, no strobe
   a_r3_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> scl_out);
   a_r3_idle_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !sample_tick);
   // R6: strobe only while high, never two in a row
   a_r6_tick_while_high: assert property (@(posedge clk) disable iff (!rst_n)
      sample_tick |-> scl_out);
   a_r6_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
      sample_tick |=> !sample_tick);
   // R8: start with the low phase
   a_r8_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(enable) |=> !scl_out);
   // R2: a low phase spans more than one cycle
   a_r2_low_min: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(scl_out) && enable) |=> !scl_out);
endmodule

bind scl_timing_gen scl_timing_chk u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable),
   .scl_out(scl_out), .sample_tick(sample_tick)
);

// File: tb/tb_scl_timing_gen.sv
module tb_scl_timing_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        hs_mode = 1'b0;
   logic [7:0]  psc = 8'd0;
   logic [15:0] low_cnt = 16'd0;
   logic [15:0] high_cnt = 16'd0;
   logic        scl_out;
   logic        sample_tick;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   scl_timing_gen dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .hs_mode(hs_mode),
      .psc(psc), .low_cnt(low_cnt), .high_cnt(high_cnt),
      .scl_out(scl_out), .sample_tick(sample_tick)
   );

   // reference model: position inside the current period
   bit m_run = 0;
   int m_pos = 0, m_div = 1, m_low = 7, m_high = 5;

   task automatic m_load();
      m_div  = int'(psc) + 1;
      m_low  = (hs_mode ? int'(low_cnt[15:8])  : int'(low_cnt[7:0]))  + 7;
      m_high = (hs_mode ? int'(high_cnt[15:8]) : int'(high_cnt[7:0])) + 5;
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_run = 0; m_pos = 0;
      end else if (!enable) begin
         m_run = 0; m_pos = 0;
      end else if (!m_run) begin
         m_run = 1; m_pos = 0; m_load();
      end else begin
         m_pos = m_pos + 1;
         if (m_pos == m_div * (m_low + m_high)) begin
            m_pos = 0; m_load();
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         check("R2 scl vs model", int'(scl_out),
               (!m_run || m_pos >= m_div * m_low) ? 1 : 0);
         check("R6 tick vs model", int'(sample_tick),
               (m_run && m_pos == m_div * (m_low + m_high / 2)) ? 1 : 0);
      end
   end

   task automatic wait_fall();
      logic prev;
      prev = scl_out;
      forever begin
         @(negedge clk);
         if (prev && !scl_out) break;
         prev = scl_out;
      end
   endtask

   // cycles from the current position until the next falling edge
   task automatic until_fall(output int n);
      logic prev;
      n = 0; prev = scl_out;
      forever begin
         @(negedge clk); n++;
         if (prev && !scl_out) break;
         prev = scl_out;
      end
   endtask

   // just after a fall: measure low length, tick offset and full period
   task automatic measure(output int lo, output int tk, output int per, output int ntk);
      lo = 1; tk = -1; per = 1; ntk = 0;
      while (!scl_out) begin @(negedge clk); lo++; per++; end
      lo--;
      for (int k = 0; scl_out; k++) begin
         if (sample_tick) begin tk = k; ntk++; end
         @(negedge clk); per++;
      end
      per--;
   endtask

   task automatic setcfg(input int p, input int l, input int h, input bit hs);
      psc = 8'(p); low_cnt = 16'(l); high_cnt = 16'(h); hs_mode = hs;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      int lo, tk, per, ntk, n1, n2;
      repeat (3) @(negedge clk);
      check("R3 reset scl", int'(scl_out), 1);
      check("R3 reset tick", int'(sample_tick), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R3 idle scl", int'(scl_out), 1);

      // 100 kHz at 48 MHz
      setcfg(1, 111, 117, 0);
      enable = 1'b1;
      @(negedge clk);
      check("R8 low after enable", int'(scl_out), 0);
      for (lo = 1; !scl_out; lo++) @(negedge clk);
      check("R8 first low full", lo - 1, 236);
      wait_fall();
      measure(lo, tk, per, ntk);
      check("R1 period 100k", per, 480);
      check("R2 low 100k", lo, 236);
      check("R6 tick offset", tk, 2 * 61);
      check("R6 one tick", ntk, 1);

      // R5: change mid-period, 400 kHz from next period
      wait_fall();
      @(negedge clk);
      setcfg(1, 23, 25, 0);
      until_fall(n1);
      check("R5 old period kept", n1 + 1, 480);
      measure(lo, tk, per, ntk);
      check("R1 period 400k", per, 120);

      setcfg(1, 5, 7, 0);
      wait_fall();
      measure(lo, tk, per, ntk);
      check("R1 period 1M", per, 48);

      // R4 high-speed selection
      setcfg(0, 16'h0364, 16'h0464, 1);
      wait_fall();
      measure(lo, tk, per, ntk);
      check("R4 hs period", per, 19);
      check("R4 hs low", lo, 10);
      setcfg(0, 16'h0364, 16'h0464, 0);
      wait_fall();
      wait_fall();
      until_fall(n2);
      check("R4 normal bytes", n2, 100 + 7 + 100 + 5);

      // R7 smallest settings
      setcfg(0, 0, 0, 0);
      wait_fall();
      measure(lo, tk, per, ntk);
      check("R7 period", per, 12);
      check("R7 low", lo, 7);
      check("R6 tick min", tk, 2);

      // R3 disable mid low phase
      setcfg(2, 4, 6, 0);
      wait_fall();
      wait_fall();
      repeat (5) @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      check("R3 release on disable", int'(scl_out), 1);
      ntk = 0;
      for (int k = 0; k < 60; k++) begin
         @(negedge clk);
         if (sample_tick || !scl_out) ntk++;
      end
      check("R3 quiet while disabled", ntk, 0);
      enable = 1'b1;
      @(negedge clk);
      for (lo = 1; !scl_out; lo++) @(negedge clk);
      check("R8 restart low full", lo - 1, 3 * 11);

      repeat (10) @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule